// File: doc/BRIEF.md
# Synchronous Serial Port with Transmit and Receive Queues

This block is a peripheral-side synchronous serial port. A processor-facing register strobe (select, direction, byte) places bytes into a four-entry transmit queue and takes bytes out of a four-entry receive queue. The transmit engine turns each queued byte into a serial stream, most significant bit first. It drives its own serial clock at half the system clock rate, a one-period frame marker and an active-low enable that is low only while the serial data line carries a valid bit. When the transmit queue is full, an interrupt line goes high.

The receive engine works from an incoming serial clock and frame marker that are taken to be exactly aligned with the system clock. It rebuilds bytes from the incoming bit stream and queues them for reading. When the transmit queue still holds data as a frame ends, the next frame follows with no idle slot: its frame marker shares the period of the previous least significant bit. The intended test arrangement ties the outgoing serial clock, marker and data straight back to the matching inputs.

Top module: `sync_serial_port`

## Requirements
- R1: While `clearN` is low at a rising `pclk` edge the port resets synchronously: `serClkOut`=0, `frameOut`=0, `txEnN`=1, `txFullIrq`=0, `rdData`=0, and both queues are empty.
- R2: `serClkOut` toggles on every `pclk` edge after reset, so one serial period is two `pclk` cycles. Outgoing bit slots start on the edges where `serClkOut` rises.
- R3: When a transfer starts from idle, `frameOut` is high for exactly one serial period with `txEnN` high, and this period comes immediately before the first data bit.
- R4: Each byte goes out most significant bit first on `txData`, each bit held for one serial period with `txEnN` low. When no bit is being sent, `txEnN` is high.
- R5: If the transmit queue is not empty when a frame's last bit slot begins, `frameOut` is high during that last bit slot and the next byte's first bit follows at once, so back-to-back frames keep `txEnN` low without a break.
- R6: A cycle with `sel`=1 and `writeEn`=1 appends `wrData` to the transmit queue (4 entries). A write while the queue is full is dropped, and that byte is never sent.
- R7: `txFullIrq` is high exactly while the transmit queue holds 4 entries.
- R8: `rdData` shows the oldest received byte, or 0 when the receive queue is empty. A cycle with `sel`=1 and `writeEn`=0 removes that byte. A read of an empty queue changes nothing.
- R9: The receiver samples `rxData` and `frameIn` on the `pclk` edges where `serClkIn` is 1. After a sample with `frameIn`=1, the next 8 samples form a byte, MSB first, which is queued on the 8th sample. The byte is discarded if the receive queue is full.
- R10: With `txData`, `serClkOut` and `frameOut` looped back to `rxData`, `serClkIn` and `frameIn`, the written bytes are read back unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | System clock |
| clearN | input | 1 | Active-low synchronous clear |
| sel | input | 1 | Port select strobe |
| writeEn | input | 1 | 1 = write to transmit queue, 0 = read from receive queue |
| wrData | input | 8 | Byte to transmit |
| rdData | output | 8 | Oldest received byte, 0 when empty |
| txFullIrq | output | 1 | Transmit queue full interrupt |
| serClkOut | output | 1 | Generated serial clock, half of pclk |
| frameOut | output | 1 | Outgoing frame-start marker |
| txData | output | 1 | Outgoing serial data |
| txEnN | output | 1 | Active-low valid/enable for txData |
| serClkIn | input | 1 | Incoming serial clock, aligned to pclk |
| frameIn | input | 1 | Incoming frame-start marker |
| rxData | input | 1 | Incoming serial data |

## Verification
The assertions take for granted that the incoming serial clock and frame marker are exact copies of the outgoing ones. They also assume that `sel` is held for whole `pclk` cycles and changes only away from the rising edge. The bench meets both: it wires the serial outputs straight to the serial inputs, and it changes every strobe on the falling `pclk` edge. No register strobe ever arrives during reset. The bench also limits each read to a byte it expects, so queue overflow happens only in the two scenarios built to cause it.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SYNC = 2'd1,
    TX_DATA = 2'd2
  } txState_t;

  typedef struct packed {
    logic txPop;    // take head of transmit queue into the shifter
    logic txShift;  // advance transmit shifter by one bit
    logic rxShift;  // capture one incoming bit
    logic rxPush;   // queue the assembled received byte
  } sportStrobe_t;

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             pclk,
  input  logic             clearN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_FULL);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = store[rdPtr];

  always_ff @(posedge pclk) begin
    if (!clearN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge pclk) begin
        if (!clearN)                              store[gi] <= '0;
        else if (doPush && wrPtr == PTR_W'(gi))   store[gi] <= din;
      end
    end
  endgenerate

endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic         pclk,
  input  logic         clearN,
  input  logic         txEmpty,
  input  logic         serClkIn,
  input  logic         frameIn,
  output sportStrobe_t strb,
  output logic         serClkOut,
  output logic         frameOut,
  output logic         txEnN
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(DATA_W - 2);

  txState_t         state, nState;
  logic [IDX_W-1:0] idx, nIdx;
  logic             phase;
  logic             frameR, nFrame;
  logic             oeNR, nOeN;
  logic             rxActive;
  logic [IDX_W-1:0] rxCnt;
  logic             slotStart;
  logic             goIdle;

  assign slotStart = !phase;   // serial clock is about to rise

  always_comb begin
    strb   = '0;
    nState = state;
    nIdx   = idx;
    nFrame = frameR;
    nOeN   = oeNR;
    goIdle = 1'b0;
    if (slotStart) begin
      unique case (state)
        TX_SYNC: begin
          nState = TX_DATA;
          nIdx   = '0;
          nOeN   = 1'b0;
          nFrame = 1'b0;
        end
        TX_DATA: begin
          if (idx != IDX_LAST) begin
            strb.txShift = 1'b1;
            nIdx   = idx + 1'b1;
            nOeN   = 1'b0;
            nFrame = (idx == IDX_PRE) && !txEmpty;
          end else if (frameR) begin
            strb.txPop = 1'b1;   // continuous: next MSB at once
            nIdx   = '0;
            nOeN   = 1'b0;
            nFrame = 1'b0;
          end else begin
            goIdle = 1'b1;
          end
        end
        default: goIdle = 1'b1;
      endcase
      if (goIdle) begin
        nOeN = 1'b1;
        if (!txEmpty) begin
          strb.txPop = 1'b1;
          nState = TX_SYNC;
          nFrame = 1'b1;
        end else begin
          nState = TX_IDLE;
          nFrame = 1'b0;
        end
      end
    end
    if (serClkIn && rxActive) begin
      strb.rxShift = 1'b1;
      strb.rxPush  = (rxCnt == IDX_LAST);
    end
  end

  always_ff @(posedge pclk) begin
    if (!clearN) begin
      phase    <= 1'b0;
      state    <= TX_IDLE;
      idx      <= '0;
      frameR   <= 1'b0;
      oeNR     <= 1'b1;
      rxActive <= 1'b0;
      rxCnt    <= '0;
    end else begin
      phase  <= ~phase;
      state  <= nState;
      idx    <= nIdx;
      frameR <= nFrame;
      oeNR   <= nOeN;
      if (serClkIn) begin
        if (rxActive) begin
          rxCnt <= rxCnt + 1'b1;
          if (rxCnt == IDX_LAST) rxActive <= 1'b0;
        end
        if (frameIn) begin
          rxActive <= 1'b1;
          rxCnt    <= '0;
        end
      end
    end
  end

  assign serClkOut = phase;
  assign frameOut  = frameR;
  assign txEnN     = oeNR;

endmodule

// File: rtl/sport_datapath.sv
module sport_datapath
  import sport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              pclk,
  input  logic              clearN,
  input  sportStrobe_t      strb,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxData,
  output logic [DATA_W-1:0] rdData,
  output logic              txData,
  output logic              txEmpty,
  output logic              txFull
);
  logic [DATA_W-1:0] txHead, txSh, rxSh, rxByte, rxHead;
  logic              rxFull, rxEmpty;

  sport_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .pclk(pclk), .clearN(clearN),
    .push(wrStrobe), .din(wrData),
    .pop(strb.txPop), .head(txHead),
    .full(txFull), .empty(txEmpty)
  );

  assign rxByte = {rxSh[DATA_W-2:0], rxData};

  sport_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .pclk(pclk), .clearN(clearN),
    .push(strb.rxPush), .din(rxByte),
    .pop(rdStrobe), .head(rxHead),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge pclk) begin
    if (!clearN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (strb.txPop)        txSh <= txHead;
      else if (strb.txShift) txSh <= {txSh[DATA_W-2:0], 1'b0};
      if (strb.rxShift)      rxSh <= rxByte;
    end
  end

  assign txData = txSh[DATA_W-1];
  assign rdData = rxEmpty ? '0 : rxHead;

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              pclk,
  input  logic              clearN,
  input  logic              sel,
  input  logic              writeEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txFullIrq,
  output logic              serClkOut,
  output logic              frameOut,
  output logic              txData,
  output logic              txEnN,
  input  logic              serClkIn,
  input  logic              frameIn,
  input  logic              rxData
);
  sportStrobe_t strb;
  logic         txEmpty;

  sport_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .pclk(pclk), .clearN(clearN), .txEmpty(txEmpty),
    .serClkIn(serClkIn), .frameIn(frameIn), .strb(strb),
    .serClkOut(serClkOut), .frameOut(frameOut), .txEnN(txEnN)
  );

  sport_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .pclk(pclk), .clearN(clearN), .strb(strb),
    .wrStrobe(sel && writeEn), .rdStrobe(sel && !writeEn),
    .wrData(wrData), .rxData(rxData), .rdData(rdData),
    .txData(txData), .txEmpty(txEmpty), .txFull(txFullIrq)
  );

endmodule

// File: rtl/sync_serial_port_checker.sv
module sync_serial_port_checker (
  input logic pclk,
  input logic clearN,
  input logic sel,
  input logic writeEn,
  input logic serClkOut,
  input logic frameOut,
  input logic txData,
  input logic txEnN,
  input logic txFullIrq
);
  // R2: serial clock flips on every edge
  a_r2_clk_toggles: assert property (@(posedge pclk) disable iff (!clearN)
    1'b1 |=> (serClkOut != $past(serClkOut)));

  // R3: marker is a full serial period, starting as the serial clock rises
  a_r3_frame_period: assert property (@(posedge pclk) disable iff (!clearN)
    $rose(frameOut) |-> serClkOut ##1 frameOut);

  // R3/R5: every first data bit is preceded by a marker period
  a_r3_marker_first: assert property (@(posedge pclk) disable iff (!clearN)
    $fell(txEnN) |-> $past(frameOut));

  // R4: a valid bit only changes at the start of a slot
  a_r4_bit_hold: assert property (@(posedge pclk) disable iff (!clearN)
    (!txEnN && $past(!txEnN) && !$stable(txData)) |-> serClkOut);

  // R7: the queue only becomes full through a write
  a_r7_irq_by_write: assert property (@(posedge pclk) disable iff (!clearN)
    $rose(txFullIrq) |-> $past(sel && writeEn));
endmodule

bind sync_serial_port sync_serial_port_checker u_chk (
  .pclk(pclk), .clearN(clearN), .sel(sel), .writeEn(writeEn),
  .serClkOut(serClkOut), .frameOut(frameOut), .txData(txData),
  .txEnN(txEnN), .txFullIrq(txFullIrq)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  localparam int CLK_PERIOD = 10;

  logic       pclk = 1'b0;
  logic       clearN = 1'b0;
  logic       sel = 1'b0;
  logic       writeEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       txFullIrq, serClkOut, frameOut, txData, txEnN;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  sync_serial_port dut (
    .pclk(pclk), .clearN(clearN), .sel(sel), .writeEn(writeEn),
    .wrData(wrData), .rdData(rdData), .txFullIrq(txFullIrq),
    .serClkOut(serClkOut), .frameOut(frameOut), .txData(txData),
    .txEnN(txEnN), .serClkIn(serClkOut), .frameIn(frameOut),
    .rxData(txData)
  );

  // longest run of consecutive low txEnN cycles
  int runLen = 0;
  int maxRun = 0;
  always @(negedge pclk) begin
    if (!txEnN) begin
      runLen = runLen + 1;
      if (runLen > maxRun) maxRun = runLen;
    end else begin
      runLen = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] b);
    @(negedge pclk);
    sel = 1'b1; writeEn = 1'b1; wrData = b;
    @(negedge pclk);
    sel = 1'b0; writeEn = 1'b0;
  endtask

  task automatic rdExpect(input logic [7:0] exp, input string req);
    @(negedge pclk);
    check(rdData == exp, req, rdData, exp);
    sel = 1'b1; writeEn = 1'b0;
    @(negedge pclk);
    sel = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic testReset();
    clearN = 1'b0;
    waitCycles(3);
    check(serClkOut == 1'b0, "R1 serClkOut", serClkOut, 0);
    check(frameOut == 1'b0, "R1 frameOut", frameOut, 0);
    check(txEnN == 1'b1, "R1 txEnN", txEnN, 1);
    check(txFullIrq == 1'b0, "R1 txFullIrq", txFullIrq, 0);
    check(rdData == 8'h00, "R1 rdData", rdData, 0);
    clearN = 1'b1;
    waitCycles(4);
    // R8: reading an empty queue gives 0 and leaves it empty
    rdExpect(8'h00, "R8 empty read");
    waitCycles(2);
    check(rdData == 8'h00 && txEnN == 1'b1, "R8 empty read no effect", rdData, 0);
  endtask

  task automatic testWaveform(input logic [7:0] b);
    int guard = 0;
    int hi = 0;
    bit prevClk;
    bit clkOk = 1'b1;
    bit bitOk = 1'b1;
    wrByte(b);
    while (!frameOut && guard < 8) begin
      @(negedge pclk);
      guard++;
    end
    check(frameOut == 1'b1, "R3 marker appears", frameOut, 1);
    prevClk = serClkOut;
    while (frameOut && hi < 6) begin
      if (!txEnN) bitOk = 1'b0;
      hi++;
      @(negedge pclk);
      if (serClkOut == prevClk) clkOk = 1'b0;
      prevClk = serClkOut;
    end
    check(hi == 2, "R3 marker lasts one serial period", hi, 2);
    check(bitOk, "R3 txEnN high during marker", bitOk, 1);
    for (int i = 7; i >= 0; i--) begin
      for (int k = 0; k < 2; k++) begin
        if (txEnN != 1'b0 || txData != b[i]) bitOk = 1'b0;
        @(negedge pclk);
        if (serClkOut == prevClk) clkOk = 1'b0;
        prevClk = serClkOut;
      end
    end
    check(bitOk, "R4 MSB-first bits with txEnN low", bitOk, 1);
    check(clkOk, "R2 serClkOut toggles each pclk", clkOk, 1);
    check(txEnN == 1'b1 && frameOut == 1'b0, "R4 idle after frame", txEnN, 1);
    rdExpect(b, "R9 looped byte received");
    rdExpect(8'h00, "R8 queue empty after read");
  endtask

  task automatic testBurstRxDrop();
    logic [7:0] vals [6] = '{8'h11, 8'h82, 8'hC3, 8'h3C, 8'h5A, 8'hE7};
    maxRun = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge pclk);
      sel = 1'b1; writeEn = 1'b1; wrData = vals[i];
    end
    @(negedge pclk);
    sel = 1'b0; writeEn = 1'b0;
    check(txFullIrq == 1'b1, "R7 irq high when queue full", txFullIrq, 1);
    waitCycles(150);
    check(txFullIrq == 1'b0, "R7 irq low after drain", txFullIrq, 0);
    check(maxRun == 80, "R5 five frames without gap", maxRun, 80);
    for (int i = 0; i < 4; i++) rdExpect(vals[i], "R10 order after burst");
    rdExpect(8'h00, "R9 fifth byte dropped on full receive queue");
  endtask

  task automatic testBurstTxDrop();
    logic [7:0] vals [6] = '{8'hA1, 8'h4B, 8'h96, 8'h0F, 8'hF0, 8'h69};
    for (int i = 0; i < 6; i++) begin
      @(negedge pclk);
      sel = 1'b1; writeEn = 1'b1; wrData = vals[i];
    end
    @(negedge pclk);
    sel = 1'b0; writeEn = 1'b0;
    waitCycles(60);
    for (int i = 0; i < 3; i++) rdExpect(vals[i], "R10 order with interleaved reads");
    waitCycles(60);
    for (int i = 3; i < 5; i++) rdExpect(vals[i], "R10 order with interleaved reads");
    rdExpect(8'h00, "R6 write to full transmit queue dropped");
    check(txEnN == 1'b1, "R6 nothing more sent", txEnN, 1);
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testWaveform(8'hA5);
    testWaveform(8'h96);
    testBurstRxDrop();
    testBurstTxDrop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule